// File: doc/BRIEF.md
# Execute-Stage Arithmetic Unit with Secondary Result

This block is the arithmetic core of a simple 32-bit execute stage. A caller presents a 5-bit opcode, an A operand and a B operand, and pulses `start`. The B operand is either a register value or a 14-bit immediate that the block sign-extends. The block returns a primary result on `cBus`. Multiply and the two divides also return a secondary result on `secResult` and raise `secWe` for one cycle, so the caller can write it to a dedicated overflow register. The secondary result is the upper product half for multiply and the remainder for the divides.

For load and store, the block drives the memory address, write data and strobes in the same cycle that `start` is accepted. A load returns the memory word one cycle later through `cBus`. A store puts the decremented A value on `cBus`. The block keeps one carry flag for chained additions.

Most operations finish one cycle after `start`. A divide with a non-zero divisor runs one quotient bit per cycle. During that time `busy` is high and any new `start` is ignored. `done` pulses for one cycle whenever a result is ready. `cBus` and `secResult` hold their value until the next operation is accepted. The one exception is a load, where `cBus` follows `loadData`.

Top module: `exec_alu`

## Requirements
- R1: When `immSel` is 1, the B operand is `{immRb, immLo}` read as a 14-bit two's-complement value and sign-extended to 32 bits. When `immSel` is 0, the B operand is `bReg`.
- R2: A `start` accepted while `busy` is low, with opcode 0x03 (AND), 0x04 (OR), 0x05 (XOR), 0x06 (ADD) or 0x08 (SUB, A minus B), gives `done` high for exactly the next cycle. In that cycle `cBus` holds the 32-bit result.
- R3: The carry flag (output `carry`) is 0 after reset and is written only by accepted ADD, ADDC and SUB:
  - ADD and ADDC store their carry-out.
  - SUB stores 1 when A >= B unsigned, that is, when there is no borrow.
  - ADDC (0x07) computes A + B + carry.
- R4: MUL (0x09) puts the low 32 bits of the unsigned 64-bit product on `cBus` and the high 32 bits on `secResult`.
- R5: DIV (0x0A) is unsigned. It puts the quotient on `cBus` and the remainder on `secResult`. With a non-zero divisor, `busy` is high for exactly 32 cycles after the accepting edge, and `done` rises in the cycle where `busy` falls.
- R6: SDIV (0x0B) divides signed operands with truncation toward zero. The remainder takes the sign of the dividend.
- R7: A divide of either kind by zero gives quotient 0xFFFFFFFF and remainder equal to A. `done` comes one cycle after `start` and `busy` never rises.
- R8: LOAD (0x01) raises `memRe` and drives `memAddr` = A + B in the cycle `start` is accepted. In the `done` cycle, `cBus` equals `loadData`.
- R9: STORE (0x02) raises `memWe` in the accepting cycle, with `memAddr` = B and `memWrData` = A. At `done`, `cBus` = A - 1.
- R10: Opcodes 0x00 and 0x0C to 0x1F give `cBus` = 0 at `done` and leave `secWe` low.
- R11: A `start` while `busy` is high is ignored:
  - no extra `done` pulse;
  - no memory strobe;
  - no change to the carry flag or to the running divide.
- R12: After reset, `busy`, `done`, `secWe`, `memWe`, `memRe` and `carry` are all 0.
- R13: `secWe` is high only in a `done` cycle, and only for MUL, DIV and SDIV.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (accepted when not busy) |
| opcode | input | 5 | Operation selector |
| aVal | input | 32 | A operand |
| bReg | input | 32 | Register B operand |
| immSel | input | 1 | Select the immediate as the B operand |
| immRb | input | 4 | Upper 4 bits of the immediate |
| immLo | input | 10 | Lower 10 bits of the immediate |
| loadData | input | 32 | Memory read word, valid one cycle after the load request |
| busy | output | 1 | Iterative divide in progress |
| done | output | 1 | One-cycle result-ready pulse |
| cBus | output | 32 | Primary result |
| secResult | output | 32 | Secondary result (high product or remainder) |
| secWe | output | 1 | Write strobe for the secondary result |
| carry | output | 1 | Stored carry flag |
| memAddr | output | 32 | Memory address for load or store |
| memWrData | output | 32 | Store data |
| memWe | output | 1 | Store strobe |
| memRe | output | 1 | Load strobe |

## Verification
Some faults sit in the divider. A stale partial remainder or an off-by-one iteration count shows up as a wrong quotient or remainder at the next `done`. The same fault can also show up as a `busy` window that is not exactly 32 cycles, so it is caught within one divide. A carry flag that is written when it should not be is hidden until the next ADDC, where it surfaces as a result one unit off. The bench therefore follows every carry-producing step, and the ignored-start case, with an ADDC. Errors in the memory-strobe timing are visible in the accepting cycle itself, and the bench checks them there.

// File: rtl/exec_alu_pkg.sv
package exec_alu_pkg;
  localparam logic [4:0] OP_LOAD  = 5'h01;
  localparam logic [4:0] OP_STORE = 5'h02;
  localparam logic [4:0] OP_AND   = 5'h03;
  localparam logic [4:0] OP_OR    = 5'h04;
  localparam logic [4:0] OP_XOR   = 5'h05;
  localparam logic [4:0] OP_ADD   = 5'h06;
  localparam logic [4:0] OP_ADDC  = 5'h07;
  localparam logic [4:0] OP_SUB   = 5'h08;
  localparam logic [4:0] OP_MUL   = 5'h09;
  localparam logic [4:0] OP_UDIV  = 5'h0A;
  localparam logic [4:0] OP_SDIV  = 5'h0B;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;    // start taken this cycle
    logic divStart;  // accepted op is an iterative divide
    logic divStep;   // one quotient bit this cycle
    logic divLast;   // final quotient bit this cycle
  } ctrlStrobe_t;
endpackage

// File: rtl/exec_alu_ctrl.sv
module exec_alu_ctrl
  import exec_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        isDivOp,
  input  logic        divByZero,
  output ctrlStrobe_t strobes,
  output logic        busy,
  output logic        done
);
  localparam int CNT_W = $clog2(DATA_W);

  typedef enum logic {S_IDLE, S_DIV} state_e;
  state_e             state;
  logic [CNT_W-1:0]   bitCnt;

  always_comb begin
    strobes.accept   = start && (state == S_IDLE);
    strobes.divStart = strobes.accept && isDivOp && !divByZero;
    strobes.divStep  = (state == S_DIV);
    strobes.divLast  = strobes.divStep && (bitCnt == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      bitCnt <= '0;
      done   <= 1'b0;
    end else begin
      done <= (strobes.accept && !strobes.divStart) || strobes.divLast;
      if (strobes.divStart) begin
        state  <= S_DIV;
        bitCnt <= CNT_W'(DATA_W - 1);
      end else if (strobes.divStep) begin
        if (bitCnt == '0) state <= S_IDLE;
        else              bitCnt <= bitCnt - 1'b1;
      end
    end
  end

  assign busy = (state == S_DIV);
endmodule

// File: rtl/exec_alu_dpath.sv
module exec_alu_dpath
  import exec_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int RB_W   = 4,
  parameter int IL_W   = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobes,
  input  logic [4:0]        opcode,
  input  logic [DATA_W-1:0] aVal,
  input  logic [DATA_W-1:0] bReg,
  input  logic              immSel,
  input  logic [RB_W-1:0]   immRb,
  input  logic [IL_W-1:0]   immLo,
  input  logic [DATA_W-1:0] loadData,
  output logic              isDivOp,
  output logic              divByZero,
  output logic [DATA_W-1:0] cBus,
  output logic [DATA_W-1:0] secResult,
  output logic              secWe,
  output logic              carry,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              memWe,
  output logic              memRe
);
  localparam int IMM_W = RB_W + IL_W;

  logic [IMM_W-1:0]    immVal;
  logic [DATA_W-1:0]   bBus;
  logic [DATA_W:0]     addSum, adcSum, subDiff;
  logic [2*DATA_W-1:0] prod;
  logic [DATA_W-1:0]   quickRes, quickSec;
  logic                quickSecWe, carryWe, newCarry;
  logic                aNeg, bNeg;
  logic [DATA_W-1:0]   aMag, bMag;

  logic [DATA_W-1:0]   resultR, secR, remR, quoR, dvsR;
  logic [4:0]          opR;
  logic                negQ, negR;
  logic [DATA_W:0]     shifted, trial;
  logic                fits;
  logic [DATA_W-1:0]   remNext, quoNext;

  assign immVal = {immRb, immLo};
  assign bBus   = immSel ? {{(DATA_W-IMM_W){immVal[IMM_W-1]}}, immVal} : bReg;

  assign addSum  = {1'b0, aVal} + {1'b0, bBus};
  assign adcSum  = addSum + {{DATA_W{1'b0}}, carry};
  assign subDiff = {1'b0, aVal} + {1'b0, ~bBus} + {{DATA_W{1'b0}}, 1'b1};
  assign prod    = {{DATA_W{1'b0}}, aVal} * {{DATA_W{1'b0}}, bBus};

  assign isDivOp   = (opcode == OP_UDIV) || (opcode == OP_SDIV);
  assign divByZero = (bBus == '0);

  assign aNeg = (opcode == OP_SDIV) && aVal[DATA_W-1];
  assign bNeg = (opcode == OP_SDIV) && bBus[DATA_W-1];
  assign aMag = aNeg ? -aVal : aVal;
  assign bMag = bNeg ? -bBus : bBus;

  // single-cycle results (divides reach here only with a zero divisor)
  always_comb begin
    quickRes   = '0;
    quickSec   = '0;
    quickSecWe = 1'b0;
    carryWe    = 1'b0;
    newCarry   = 1'b0;
    case (opcode)
      OP_STORE: quickRes = aVal - 1'b1;
      OP_AND:   quickRes = aVal & bBus;
      OP_OR:    quickRes = aVal | bBus;
      OP_XOR:   quickRes = aVal ^ bBus;
      OP_ADD: begin
        quickRes = addSum[DATA_W-1:0];
        carryWe  = 1'b1;
        newCarry = addSum[DATA_W];
      end
      OP_ADDC: begin
        quickRes = adcSum[DATA_W-1:0];
        carryWe  = 1'b1;
        newCarry = adcSum[DATA_W];
      end
      OP_SUB: begin
        quickRes = subDiff[DATA_W-1:0];
        carryWe  = 1'b1;
        newCarry = subDiff[DATA_W];
      end
      OP_MUL: begin
        quickRes   = prod[DATA_W-1:0];
        quickSec   = prod[2*DATA_W-1:DATA_W];
        quickSecWe = 1'b1;
      end
      OP_UDIV, OP_SDIV: begin
        quickRes   = '1;
        quickSec   = aVal;
        quickSecWe = 1'b1;
      end
      default: ;
    endcase
  end

  // restoring divide step
  assign shifted = {remR, quoR[DATA_W-1]};
  assign trial   = shifted - {1'b0, dvsR};
  assign fits    = !trial[DATA_W];
  assign remNext = fits ? trial[DATA_W-1:0] : shifted[DATA_W-1:0];
  assign quoNext = {quoR[DATA_W-2:0], fits};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultR <= '0;
      secR    <= '0;
      secWe   <= 1'b0;
      carry   <= 1'b0;
      opR     <= '0;
      remR    <= '0;
      quoR    <= '0;
      dvsR    <= '0;
      negQ    <= 1'b0;
      negR    <= 1'b0;
    end else begin
      secWe <= 1'b0;
      if (strobes.accept) begin
        opR <= opcode;
        if (carryWe) carry <= newCarry;
        if (strobes.divStart) begin
          remR <= '0;
          quoR <= aMag;
          dvsR <= bMag;
          negQ <= aNeg ^ bNeg;
          negR <= aNeg;
        end else begin
          resultR <= quickRes;
          secWe   <= quickSecWe;
          if (quickSecWe) secR <= quickSec;
        end
      end
      if (strobes.divStep) begin
        remR <= remNext;
        quoR <= quoNext;
        if (strobes.divLast) begin
          resultR <= negQ ? -quoNext : quoNext;
          secR    <= negR ? -remNext : remNext;
          secWe   <= 1'b1;
        end
      end
    end
  end

  assign cBus      = (opR == OP_LOAD) ? loadData : resultR;
  assign secResult = secR;

  assign memRe     = strobes.accept && (opcode == OP_LOAD);
  assign memWe     = strobes.accept && (opcode == OP_STORE);
  assign memAddr   = (opcode == OP_STORE) ? bBus : addSum[DATA_W-1:0];
  assign memWrData = aVal;
endmodule

// File: rtl/exec_alu.sv
module exec_alu
  import exec_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int RB_W   = 4,
  parameter int IL_W   = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [4:0]        opcode,
  input  logic [DATA_W-1:0] aVal,
  input  logic [DATA_W-1:0] bReg,
  input  logic              immSel,
  input  logic [RB_W-1:0]   immRb,
  input  logic [IL_W-1:0]   immLo,
  input  logic [DATA_W-1:0] loadData,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] cBus,
  output logic [DATA_W-1:0] secResult,
  output logic              secWe,
  output logic              carry,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              memWe,
  output logic              memRe
);
  ctrlStrobe_t strobes;
  logic        isDivOp, divByZero;

  exec_alu_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .isDivOp(isDivOp), .divByZero(divByZero),
    .strobes(strobes), .busy(busy), .done(done)
  );

  exec_alu_dpath #(.DATA_W(DATA_W), .RB_W(RB_W), .IL_W(IL_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .opcode(opcode),
    .aVal(aVal), .bReg(bReg), .immSel(immSel), .immRb(immRb),
    .immLo(immLo), .loadData(loadData),
    .isDivOp(isDivOp), .divByZero(divByZero),
    .cBus(cBus), .secResult(secResult), .secWe(secWe), .carry(carry),
    .memAddr(memAddr), .memWrData(memWrData), .memWe(memWe), .memRe(memRe)
  );
endmodule

// File: rtl/exec_alu_chk.sv
module exec_alu_chk
  import exec_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [4:0]        opcode,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] cBus,
  input logic              secWe,
  input logic              carry,
  input logic              memWe,
  input logic              memRe
);
  // R5
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  // R5
  busy_fall_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R13
  secwe_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    secWe |-> done);

  // R8
  mem_strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memWe && memRe));

  // R11
  no_mem_while_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (!memWe && !memRe));

  // R2
  single_cycle_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && opcode != OP_UDIV && opcode != OP_SDIV) |=> done);

  // R10
  undef_op_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && (opcode == 5'h00 || opcode >= 5'h0C)) |=> (done && cBus == '0 && !secWe));

  // R3
  carry_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(start && !busy && (opcode == OP_ADD || opcode == OP_ADDC || opcode == OP_SUB))
      |=> $stable(carry));
endmodule

bind exec_alu exec_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .opcode(opcode), .busy(busy),
  .done(done), .cBus(cBus), .secWe(secWe), .carry(carry),
  .memWe(memWe), .memRe(memRe)
);

// File: tb/test_exec_alu.sv
module test_exec_alu;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  opcode = '0;
  logic [31:0] aVal = '0, bReg = '0, loadData = '0;
  logic        immSel = 1'b0;
  logic [3:0]  immRb = '0;
  logic [9:0]  immLo = '0;
  logic        busy, done, secWe, carry, memWe, memRe;
  logic [31:0] cBus, secResult, memAddr, memWrData;

  int checks = 0;
  int fails  = 0;
  logic expCarry = 1'b0;

  typedef struct {
    logic [31:0] c;
    logic [31:0] s;
    logic        sWe;
    logic        cy;
    string       req;
  } exp_t;
  exp_t expQ[$];

  always #2 clk = ~clk;

  exec_alu i_exec_alu (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode), .aVal(aVal),
    .bReg(bReg), .immSel(immSel), .immRb(immRb), .immLo(immLo),
    .loadData(loadData), .busy(busy), .done(done), .cBus(cBus),
    .secResult(secResult), .secWe(secWe), .carry(carry), .memAddr(memAddr),
    .memWrData(memWrData), .memWe(memWe), .memRe(memRe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: scoreboard compare on every done
  always @(negedge clk) begin
    if (rstN) begin
      if (done) begin
        if (expQ.size() == 0) chk("R11 unexpected done", 32'd1, 32'd0);
        else begin
          exp_t e;
          e = expQ.pop_front();
          chk({e.req, " cBus"}, cBus, e.c);
          chk("R13 secWe", {31'd0, secWe}, {31'd0, e.sWe});
          if (e.sWe) chk({e.req, " secResult"}, secResult, e.s);
          chk("R3 carry", {31'd0, carry}, {31'd0, e.cy});
        end
      end else if (secWe) chk("R13 secWe without done", 32'd1, 32'd0);
    end
  end

  // driver: model result, push expectation, drive one op and wait
  task automatic issue(input logic [4:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic useImm,
                       input logic [13:0] imm, input string req,
                       input int expBusy);
    logic [31:0] bv, c, s;
    logic        we;
    logic [32:0] t;
    logic [63:0] p;
    int          busyCnt;
    bv = useImm ? {{18{imm[13]}}, imm} : b;
    c = '0; s = '0; we = 1'b0;
    case (op)
      5'h01: c = loadData;
      5'h02: c = a - 32'd1;
      5'h03: c = a & bv;
      5'h04: c = a | bv;
      5'h05: c = a ^ bv;
      5'h06: begin t = {1'b0, a} + {1'b0, bv}; c = t[31:0]; expCarry = t[32]; end
      5'h07: begin t = {1'b0, a} + {1'b0, bv} + {32'd0, expCarry}; c = t[31:0]; expCarry = t[32]; end
      5'h08: begin c = a - bv; expCarry = (a >= bv); end
      5'h09: begin p = {32'd0, a} * {32'd0, bv}; c = p[31:0]; s = p[63:32]; we = 1'b1; end
      5'h0A: begin
        we = 1'b1;
        if (bv == 0) begin c = '1; s = a; end
        else begin c = a / bv; s = a % bv; end
      end
      5'h0B: begin
        we = 1'b1;
        if (bv == 0) begin c = '1; s = a; end
        else begin c = $signed(a) / $signed(bv); s = $signed(a) % $signed(bv); end
      end
      default: ;
    endcase
    expQ.push_back('{c: c, s: s, sWe: we, cy: expCarry, req: req});
    @(negedge clk);
    opcode = op; aVal = a; bReg = b; immSel = useImm;
    immRb = imm[13:10]; immLo = imm[9:0]; start = 1'b1;
    #1;
    if (op == 5'h01) begin
      chk("R8 memRe", {31'd0, memRe}, 32'd1);
      chk("R8 memAddr", memAddr, a + bv);
    end else if (op == 5'h02) begin
      chk("R9 memWe", {31'd0, memWe}, 32'd1);
      chk("R9 memAddr", memAddr, bv);
      chk("R9 memWrData", memWrData, a);
    end
    @(negedge clk);
    start = 1'b0;
    busyCnt = 0;
    while (!done && busyCnt < 100) begin
      if (busy) busyCnt++;
      @(negedge clk);
    end
    chk({req, " busy cycles"}, busyCnt, expBusy);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 busy", {31'd0, busy}, 32'd0);
    chk("R12 done", {31'd0, done}, 32'd0);
    chk("R12 secWe", {31'd0, secWe}, 32'd0);
    chk("R12 mem strobes", {30'd0, memWe, memRe}, 32'd0);
    chk("R12 carry", {31'd0, carry}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 logic and arithmetic, R1 operand selection
    issue(5'h03, 32'hF0F0_1234, 32'h0FF0_FF00, 1'b0, 14'd0, "R2 AND", 0);
    issue(5'h04, 32'h0000_1000, 32'd0, 1'b1, 14'h2001, "R1 OR imm neg", 0);
    issue(5'h05, 32'hAAAA_5555, 32'hFFFF_0000, 1'b0, 14'd0, "R2 XOR", 0);
    issue(5'h06, 32'd100, 32'd0, 1'b1, 14'h3FFF, "R1 ADD imm -1", 0);
    issue(5'h06, 32'd5, 32'd0, 1'b1, 14'h1FFF, "R1 ADD imm max", 0);
    // R3 carry chain
    issue(5'h06, 32'hFFFF_FFF0, 32'h20, 1'b0, 14'd0, "R3 ADD carry out", 0);
    issue(5'h07, 32'd1, 32'd2, 1'b0, 14'd0, "R3 ADDC with carry", 0);
    issue(5'h08, 32'd3, 32'd7, 1'b0, 14'd0, "R3 SUB borrow", 0);
    issue(5'h07, 32'd10, 32'd10, 1'b0, 14'd0, "R3 ADDC carry clear", 0);
    issue(5'h08, 32'd9, 32'd9, 1'b0, 14'd0, "R3 SUB no borrow", 0);
    issue(5'h03, 32'd1, 32'd1, 1'b0, 14'd0, "R3 AND keeps carry", 0);
    issue(5'h07, 32'd0, 32'd0, 1'b0, 14'd0, "R3 ADDC after AND", 0);
    // R4 multiply
    issue(5'h09, 32'hDEAD_BEEF, 32'h1234_5678, 1'b0, 14'd0, "R4 MUL", 0);
    issue(5'h09, 32'hFFFF_FFFF, 32'd0, 1'b1, 14'h3FFF, "R4 MUL imm", 0);
    // R5 unsigned divide
    issue(5'h0A, 32'd1000, 32'd7, 1'b0, 14'd0, "R5 DIV", 32);
    issue(5'h0A, 32'hFFFF_FFFF, 32'h10, 1'b0, 14'd0, "R5 DIV large", 32);
    issue(5'h0A, 32'd3, 32'd9, 1'b0, 14'd0, "R5 DIV small", 32);
    // R6 signed divide
    issue(5'h0B, -32'sd100, 32'd7, 1'b0, 14'd0, "R6 SDIV neg/pos", 32);
    issue(5'h0B, 32'd100, -32'sd7, 1'b0, 14'd0, "R6 SDIV pos/neg", 32);
    issue(5'h0B, -32'sd100, 32'd0, 1'b1, 14'h3FF9, "R6 SDIV neg/neg imm", 32);
    // R7 divide by zero
    issue(5'h0A, 32'd1234, 32'd0, 1'b0, 14'd0, "R7 DIV by zero", 0);
    issue(5'h0B, -32'sd55, 32'd0, 1'b0, 14'd0, "R7 SDIV by zero", 0);
    // R8 load, R9 store
    loadData = 32'hCAFE_F00D;
    issue(5'h01, 32'h100, 32'd0, 1'b1, 14'h3FFE, "R8 LOAD", 0);
    issue(5'h02, 32'd0, 32'h3FFF, 1'b0, 14'd0, "R9 STORE", 0);
    // R10 undefined opcodes
    issue(5'h00, 32'd7, 32'd8, 1'b0, 14'd0, "R10 op 0x00", 0);
    issue(5'h1F, 32'd7, 32'd8, 1'b0, 14'd0, "R10 op 0x1F", 0);

    // R11 start while busy is ignored
    expQ.push_back('{c: 32'd14, s: 32'd2, sWe: 1'b1, cy: expCarry, req: "R11 DIV survives"});
    @(negedge clk);
    opcode = 5'h0A; aVal = 32'd100; bReg = 32'd7; immSel = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    opcode = 5'h06; aVal = 32'hFFFF_FFFF; bReg = 32'hFFFF_FFFF; start = 1'b1;
    #1;
    chk("R11 no memWe/memRe while busy", {30'd0, memWe, memRe}, 32'd0);
    @(negedge clk);
    start = 1'b0;
    repeat (40) @(negedge clk);
    chk("R11 queue drained", expQ.size(), 32'd0);
    chk("R11 carry unchanged", {31'd0, carry}, {31'd0, expCarry});
    issue(5'h07, 32'd1, 32'd1, 1'b0, 14'd0, "R11 ADDC after ignored ADD", 0);

    repeat (3) @(negedge clk);
    chk("R2 all results seen", expQ.size(), 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule